// File: doc/BRIEF.md
# Multichannel Noise-Shaped DC Blocker

This block strips the DC component from several interleaved audio channels with one shared fixed-point datapath. Each channel runs a first difference of its input and feeds it into a leaky integrator whose pole sits just below one. The integrator keeps a double-width accumulator. Only the saturated high word is multiplied by the pole coefficient, so the bits dropped by truncation stay in the low word and re-enter on the next sample. This first-order noise shaping puts a zero at DC, and the integrator therefore cannot hold a DC limit cycle.

Samples arrive on a valid/ready stream, each tagged with a channel number. They come in bursts of `BURST_LEN` consecutive samples for one channel. At the start of a burst, that channel's state (last input, accumulator high and low words) is taken from a small register file. It is written back when the burst completes. For each accepted sample the block emits the truncated state from before that sample on a valid/ready output stream. The output is therefore one sample late.

Back-pressure rules:
- `in_ready` is high whenever the output register is empty or is being drained in the same cycle.
- A sample is consumed on any cycle with `in_valid && in_ready`.
- The output holds `out_data` and `out_chan` steady while `out_valid && !out_ready`.
- There is no other buffering.

Top module: `dcb_noise_shaped`

## Requirements
- R1: After reset `out_valid` and `err_flag` are low, `in_ready` is high, and every channel's last input and accumulator are zero, so the first output of any channel after reset is 0.
- R2: For an accepted sample x[n] of channel c, the output is yt = sat16(floor(A/2^16)), where A is channel c's 40-bit accumulator before the sample. A then becomes A + (x[n] − x[n−1])·2^16 + 2·COEF·yt, with COEF the pole minus one in Q1.15 and samples in Q1.15.
- R3: Under constant input the output settles to −1 or 0 and does not stick at a non-zero value, because the low word carries the truncation error forward.
- R4: Outputs appear in acceptance order, and each output's `out_chan` equals the channel of its burst.
- R5: Each channel's state is independent. Bursts of different channels may come in any order, and each channel continues from its own saved state.
- R6: A sample accepted in the middle of a burst whose tag differs from the burst channel is consumed, produces no output, and neither advances the burst nor changes any channel's state.
- R7: Such a mismatch sets `err_flag`, which stays high until reset.
- R8: While `out_valid` is high and `out_ready` low, `in_ready` is low and `out_data` and `out_chan` hold. No sample is lost or duplicated under any pattern of `out_ready`.
- R9: The high word is clamped to [−32768, 32767]. The clamped value is both the output and the multiplier operand.
- R10: An accepted in-burst sample makes `out_valid` high on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample can be taken |
| in_data | input | 16 | Input sample, signed Q1.15 |
| in_chan | input | log2(NUM_CH) | Channel tag of the input sample |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream can take the output |
| out_data | output | 16 | Filtered sample, signed Q1.15 |
| out_chan | output | log2(NUM_CH) | Channel of the output sample |
| err_flag | output | 1 | Sticky flag for mismatched channel tags |

## Verification
The checker watches the stream rules on every cycle:
- output hold and input stall under back-pressure;
- the one-cycle acceptance-to-output latency and its channel tag;
- the sticky error after a mismatched tag, with no output;
- the accumulator staying inside its guard range.

Only the bench scenarios can show the numeric behaviour. It compares every output against a reference recurrence across interleaved channels, and checks saturation at both rails. It confirms that a constant negative input decays to within one LSB of zero rather than freezing at −1, and that a rejected sample leaves every channel's later outputs unchanged.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
  localparam int SMP_W = 16;
  localparam int LOW_W = 16;
  localparam int GRD_W = 8;
  localparam int HI_W  = GRD_W + SMP_W;
  localparam int ACC_W = HI_W + LOW_W;

  typedef logic signed [SMP_W-1:0] smp_t;
  typedef logic signed [ACC_W-1:0] acc_t;

  typedef struct packed {
    smp_t x_last;
    acc_t acc;
  } ch_state_t;

  function automatic smp_t clamp_hi(input acc_t a);
    logic signed [HI_W-1:0] hi;
    hi = a[ACC_W-1:LOW_W];
    if (hi > $signed({{GRD_W{1'b0}}, 1'b0, {(SMP_W-1){1'b1}}}))
      return {1'b0, {(SMP_W-1){1'b1}}};
    else if (hi < $signed({{GRD_W{1'b1}}, 1'b1, {(SMP_W-1){1'b0}}}))
      return {1'b1, {(SMP_W-1){1'b0}}};
    else
      return hi[SMP_W-1:0];
  endfunction
endpackage

// File: rtl/dcb_state_bank.sv
module dcb_state_bank
  import dcb_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CH_W-1:0] rd_idx,
  output ch_state_t       rd_state,
  input  logic            wr_en,
  input  logic [CH_W-1:0] wr_idx,
  input  ch_state_t       wr_state
);
  ch_state_t slots [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        slots[g] <= '0;
      else if (wr_en && wr_idx == CH_W'(g))
        slots[g] <= wr_state;
    end
  end

  assign rd_state = slots[rd_idx];
endmodule

// File: rtl/dcb_datapath.sv
module dcb_datapath
  import dcb_pkg::*;
#(
  parameter int COEF     = -3,
  parameter int USE_GAIN = 0,
  parameter int GAIN     = 32766
) (
  input  ch_state_t cur,
  input  smp_t      x_in,
  output ch_state_t nxt,
  output smp_t      y_out
);
  localparam logic signed [SMP_W-1:0] COEF_V = SMP_W'(COEF);
  localparam logic signed [SMP_W:0]   GAIN_V = (SMP_W+1)'(GAIN);

  logic signed [SMP_W:0]     diff;
  logic signed [2*SMP_W-1:0] fb_prod;
  acc_t                      ff_term;
  acc_t                      fb_term;

  assign y_out   = clamp_hi(cur.acc);
  assign diff    = (SMP_W+1)'($signed(x_in)) - (SMP_W+1)'($signed(cur.x_last));
  assign fb_prod = (2*SMP_W)'(COEF_V) * (2*SMP_W)'(y_out);
  assign fb_term = acc_t'(fb_prod) <<< 1;

  if (USE_GAIN != 0) begin : g_gain
    logic signed [2*SMP_W+1:0] g_prod;
    assign g_prod  = (2*SMP_W+2)'(GAIN_V) * (2*SMP_W+2)'(diff);
    assign ff_term = acc_t'(g_prod) <<< 1;
  end else begin : g_plain
    assign ff_term = acc_t'(diff) <<< LOW_W;
  end

  assign nxt.acc    = cur.acc + ff_term + fb_term;
  assign nxt.x_last = x_in;
endmodule

// File: rtl/dcb_burst_ctrl.sv
module dcb_burst_ctrl #(
  parameter int NUM_CH    = 8,
  parameter int BURST_LEN = 4,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int CNT_W = $clog2(BURST_LEN + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fire,
  input  logic [CH_W-1:0] tag,
  output logic            take,
  output logic            first,
  output logic            last,
  output logic            in_burst,
  output logic [CH_W-1:0] burst_ch,
  output logic [CH_W-1:0] active_ch,
  output logic            err_flag
);
  logic [CNT_W-1:0] beat_q;
  logic             tag_ok;

  assign in_burst  = (beat_q != '0);
  assign first     = !in_burst;
  assign last      = (beat_q == CNT_W'(BURST_LEN - 1));
  assign tag_ok    = !in_burst || (tag == burst_ch);
  assign take      = fire && tag_ok;
  assign active_ch = in_burst ? burst_ch : tag;

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q   <= '0;
      burst_ch <= '0;
      err_flag <= 1'b0;
    end else begin
      if (take) begin
        beat_q <= last ? '0 : beat_q + 1'b1;
        if (first) burst_ch <= tag;
      end
      if (fire && !tag_ok) err_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/dcb_noise_shaped.sv
module dcb_noise_shaped
  import dcb_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int BURST_LEN = 4,
  parameter int COEF      = -3,
  parameter int USE_GAIN  = 0,
  parameter int GAIN      = 32766,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SMP_W-1:0] in_data,
  input  logic [CH_W-1:0]  in_chan,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SMP_W-1:0] out_data,
  output logic [CH_W-1:0]  out_chan,
  output logic             err_flag
);
  logic            take, first, last, in_burst;
  logic [CH_W-1:0] burst_ch, active_ch;
  ch_state_t       bank_rd, work_q, cur, nxt;
  smp_t            y_out;

  assign in_ready = !out_valid || out_ready;

  dcb_burst_ctrl #(.NUM_CH(NUM_CH), .BURST_LEN(BURST_LEN)) u_ctrl (
    .clk(clk), .rst(rst), .fire(in_valid && in_ready), .tag(in_chan),
    .take(take), .first(first), .last(last), .in_burst(in_burst),
    .burst_ch(burst_ch), .active_ch(active_ch), .err_flag(err_flag)
  );

  dcb_state_bank #(.NUM_CH(NUM_CH)) u_bank (
    .clk(clk), .rst(rst), .rd_idx(in_chan), .rd_state(bank_rd),
    .wr_en(take && last), .wr_idx(active_ch), .wr_state(nxt)
  );

  assign cur = first ? bank_rd : work_q;

  dcb_datapath #(.COEF(COEF), .USE_GAIN(USE_GAIN), .GAIN(GAIN)) u_dp (
    .cur(cur), .x_in(in_data), .nxt(nxt), .y_out(y_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      work_q    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_chan  <= '0;
    end else begin
      if (take) begin
        work_q    <= nxt;
        out_valid <= 1'b1;
        out_data  <= y_out;
        out_chan  <= active_ch;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dcb_checker.sv
module dcb_checker
  import dcb_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [CH_W-1:0]  in_chan,
  input logic             out_valid,
  input logic             out_ready,
  input logic [SMP_W-1:0] out_data,
  input logic [CH_W-1:0]  out_chan,
  input logic             err_flag,
  input logic             in_burst,
  input logic [CH_W-1:0]  burst_ch,
  input logic [ACC_W-1:0] acc_w
);
  logic rst_d;
  logic good, bad;
  assign good = in_valid && in_ready && (!in_burst || in_chan == burst_ch);
  assign bad  = in_valid && in_ready && in_burst && in_chan != burst_ch;

  always_ff @(posedge clk) rst_d <= rst;

  always @(posedge clk) begin
    if (rst_d) begin
      assert_reset_clear_R1: assert (!out_valid && !err_flag);
    end
  end

  assert_out_hold_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_chan));

  assert_in_stall_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  assert_latency_R10: assert property (@(posedge clk) disable iff (rst)
    good |=> out_valid && out_chan == $past(in_chan));

  assert_drop_R6: assert property (@(posedge clk) disable iff (rst)
    bad && out_ready |=> !out_valid && err_flag);

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);

  assert_acc_range_R2: assert property (@(posedge clk) disable iff (rst)
    (acc_w[ACC_W-1:SMP_W+LOW_W+1] == '0) || (acc_w[ACC_W-1:SMP_W+LOW_W+1] == '1));
endmodule

bind dcb_noise_shaped dcb_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_chan(in_chan), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_chan(out_chan), .err_flag(err_flag),
  .in_burst(in_burst), .burst_ch(burst_ch), .acc_w(work_q.acc)
);

// File: tb/tb_dcb_noise_shaped.sv
module tb_dcb_noise_shaped;
  localparam int NUM_CH = 8;
  localparam int BURST_LEN = 4;
  localparam int COEF = -2048;
  localparam int CH_W = $clog2(NUM_CH);

  typedef struct {
    int ch;
    int val;
    bit settle;
  } exp_t;

  logic clk = 0, rst = 1;
  logic in_valid = 0, in_ready, out_valid, out_ready = 1, err_flag;
  logic [15:0] in_data = '0;
  logic [CH_W-1:0] in_chan = '0;
  logic signed [15:0] out_data;
  logic [CH_W-1:0] out_chan;

  int checks = 0, fails = 0;
  bit done = 0, bp_en = 0, settle_tag = 0;
  exp_t exp_q[$];
  int m_x[NUM_CH];
  longint m_acc[NUM_CH];
  int beat = 0, bch = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  dcb_noise_shaped #(.NUM_CH(NUM_CH), .BURST_LEN(BURST_LEN), .COEF(COEF)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_chan(in_chan), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_chan(out_chan),
    .err_flag(err_flag)
  );

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int sat16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  task automatic model_clear();
    for (int i = 0; i < NUM_CH; i++) begin
      m_x[i] = 0;
      m_acc[i] = 0;
    end
    beat = 0;
    bch = 0;
  endtask

  task automatic send(int ch, int x);
    exp_t e;
    int yt;
    @(negedge clk);
    in_valid = 1;
    in_data = 16'(x);
    in_chan = CH_W'(ch);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    if (beat != 0 && ch != bch) begin
      // R6: mismatched tag, no output expected, state untouched
    end else begin
      if (beat == 0) bch = ch;
      yt = sat16(m_acc[ch] >>> 16);
      e.ch = ch;
      e.val = yt;
      e.settle = settle_tag;
      exp_q.push_back(e);
      m_acc[ch] = m_acc[ch] + (longint'(x - m_x[ch]) <<< 16) + 2 * longint'(COEF * yt);
      m_x[ch] = x;
      beat = (beat + 1) % BURST_LEN;
    end
    #1 in_valid = 0;
  endtask

  task automatic burst(int ch, int base, int step);
    for (int i = 0; i < BURST_LEN; i++) send(ch, base + i * step);
  endtask

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 200) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
  endtask

  // back-pressure generator
  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    #1 out_ready = bp_en ? lfsr[0] : 1'b1;
  end

  // scoreboard monitor
  logic stall_prev = 0;
  logic signed [15:0] data_prev;
  logic [CH_W-1:0] chan_prev;
  always @(negedge clk) begin
    if (!rst) begin
      if (stall_prev) begin
        check(out_valid && out_data == data_prev && out_chan == chan_prev,
              "R8 hold under stall", int'(out_data), int'(data_prev));
      end
      stall_prev = out_valid && !out_ready;
      data_prev = out_data;
      chan_prev = out_chan;
      if (stall_prev) check(!in_ready, "R8 in_ready low while stalled", int'(in_ready), 0);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R6 unexpected output", int'(out_data), 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(int'(out_chan) == e.ch, "R4 channel order", int'(out_chan), e.ch);
          if (e.val == 32767 || e.val == -32768)
            check(int'(out_data) == e.val, "R9 saturated output", int'(out_data), e.val);
          else
            check(int'(out_data) == e.val, "R2 recurrence output", int'(out_data), e.val);
          if (e.settle)
            check(out_data == 0 || out_data == -1, "R3 settled near zero", int'(out_data), 0);
        end
      end
    end
  end

  initial begin
    repeat (1000000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (4) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R1 reset state
    check(!out_valid, "R1 out_valid after reset", int'(out_valid), 0);
    check(!err_flag, "R1 err_flag after reset", int'(err_flag), 0);
    check(in_ready, "R1 in_ready after reset", int'(in_ready), 1);

    // R2 / R5: one burst per channel, varied patterns, interleaved order
    burst(3, 1000, 250);
    burst(0, -5000, -700);
    burst(5, 20000, -9000);
    burst(3, 4000, 0);
    burst(1, 300, 300);
    burst(0, 7, 1);
    burst(5, -1, 0);
    drain();

    // R9: saturation at both rails on a fresh channel
    send(7, -32768);
    send(7, 32767);
    send(7, 32767);
    send(7, 32767);
    burst(7, -32768, 0);
    drain();

    // R6 / R7: mismatched tag mid-burst
    send(2, 1500);
    send(2, -1500);
    send(6, 9999);
    @(negedge clk);
    check(err_flag, "R7 err_flag set on mismatch", int'(err_flag), 1);
    check(!out_valid, "R6 no output for rejected sample", int'(out_valid), 0);
    send(2, 2500);
    send(2, 100);
    burst(6, 50, 10);  // channel 6 continues from its untouched state
    drain();
    check(err_flag, "R7 err_flag stays set", int'(err_flag), 1);

    // R8: random back-pressure across several channels
    bp_en = 1;
    for (int k = 0; k < 12; k++) burst(k % NUM_CH, 1000 * k - 6000, 333 - 60 * k);
    bp_en = 0;
    drain();

    // R3: constant negative input decays to within one LSB of zero
    for (int k = 0; k < 100; k++) begin
      settle_tag = (k >= 92);
      burst(4, -10000, 0);
    end
    settle_tag = 0;
    drain();
    check(exp_q.size() == 0, "R6 no missing or extra outputs", exp_q.size(), 0);

    // R1 / R7: second reset clears flag and state
    @(negedge clk);
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    model_clear();
    @(negedge clk);
    check(!err_flag, "R7 err_flag cleared only by reset", int'(err_flag), 0);
    check(!out_valid, "R1 out_valid after second reset", int'(out_valid), 0);
    burst(4, 1000, 0);
    drain();
    check(exp_q.size() == 0, "R10 every accepted sample produced output", exp_q.size(), 0);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule